// File: doc/BRIEF.md
# Hold Mode Wake-Up Sequencer

This block decides when a small 4-bit controller core may stop its oscillator and when it may run again. The core asks to sleep with a one-cycle hold-instruction strobe. The request is honoured only while the external hold-request pin is low. In the sleeping state the oscillator enable and the core-run enable are both dropped. When the hold-request pin goes high, the oscillator is enabled again and a stabilisation wait runs. At the end of the wait the core is released and timer 0 receives a preload value.

A low level on the external reset pin is honoured only while the hold-request pin is high. While the hold-request pin is low, the reset pin has no effect, so a sleeping or running core cannot be reset from that pin. Every valid reset asserts the core reset. When the reset is released, the same stabilisation wait runs as after a hold exit. Both external pins pass through two-flop synchronisers before any decision is made. The current state is brought out so that it can be observed.

Top module: `hold_wake_seq`

## Requirements
- R1: The state output uses the codes RUN=0, HOLD=1, WAIT=2 and RESET=3. After the power-on reset `rst_ni` is released, with the reset pin low, the block is in RESET with core_rst_o=1, core_run_o=0 and osc_en_o=1.
- R2: In RUN, a hold strobe while the synchronised hold pin is low moves the block to HOLD on the next clock. In HOLD, osc_en_o=0 and core_run_o=0.
- R3: In RUN, a hold strobe while the hold pin is high is ignored: the state stays RUN and osc_en_o and core_run_o stay 1.
- R4: In HOLD, a high level on the hold pin moves the block to WAIT. In WAIT, osc_en_o=1 and core_run_o=0.
- R5: WAIT lasts exactly WAIT_CYCLES clocks (16384 by default), and the block then enters RUN.
- R6: On the first RUN cycle after WAIT, t0_load_o is high for exactly one cycle, together with core_run_o, and t0_value_o is 0xFFC.
- R7: A reset pin that is low while the hold pin is high moves the block to RESET from any state, with core_rst_o=1. When the reset pin is released, the block enters WAIT.
- R8: A reset pin that is low while the hold pin is low is ignored. In RUN or HOLD, the state does not change and core_rst_o stays 0.
- R9: A valid reset during WAIT discards the partial count. The next WAIT again lasts a full WAIT_CYCLES clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| hold_cmd_i | input | 1 | One-cycle hold-instruction strobe from the core |
| hold_pin_i | input | 1 | Asynchronous hold-request pin (low = hold allowed, high = wake up) |
| res_pin_ni | input | 1 | Asynchronous reset pin, active low |
| osc_en_o | output | 1 | Oscillator enable |
| core_run_o | output | 1 | Core execution enable |
| core_rst_o | output | 1 | Core reset |
| t0_load_o | output | 1 | Timer 0 preload strobe |
| t0_value_o | output | 12 | Timer 0 preload value |
| state_o | output | 2 | Current state code |

## Verification
The bench measures the exact length of every WAIT. A counter that is off by one, or that keeps a stale count after a reset cut a wait short, shows up as a length other than 16384. The bench also pulls the reset pin low while the hold pin is low, both in RUN and in HOLD. A design that forgot the masking would assert the core reset or leave HOLD. It sends a hold strobe with the pin high, which a design that ignored the pin gate would wrongly accept. Finally, it checks that the preload strobe is a single cycle and lines up with the first run cycle, which catches a strobe that is late, early or stuck high.

// File: rtl/hws_pkg.sv
package hws_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESET = 2'd3
  } hws_state_e;
endpackage

// File: rtl/hws_sync.sv
module hws_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= {STAGES{RST_VAL}};
        else         q <= {q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/hws_wait_cnt.sv
module hws_wait_cnt #(
  parameter int WAIT_CYCLES = 16384
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = $clog2(WAIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

  logic [CW-1:0] cnt;

  // cleared whenever the wait is not running, so any re-entry starts from zero
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt <= '0;
    else if (!en_i)         cnt <= '0;
    else if (cnt != LAST)   cnt <= cnt + 1'b1;

  assign done_o = en_i && (cnt == LAST);

  a_r5_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= LAST);
  a_r9_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt == '0);
endmodule

// File: rtl/hws_fsm.sv
module hws_fsm
  import hws_pkg::*;
#(
  parameter int T0_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_cmd_i,
  input  logic            hold_s_i,
  input  logic            res_s_ni,
  input  logic            done_i,
  output logic            cnt_en_o,
  output logic            osc_en_o,
  output logic            core_run_o,
  output logic            core_rst_o,
  output logic            t0_load_o,
  output hws_state_e      state_o
);
  hws_state_e state_q, state_d;
  logic       load_q;
  logic       valid_rst;

  // reset pin counts only while the hold pin is high
  assign valid_rst = !res_s_ni && hold_s_i;

  always_comb begin
    state_d = state_q;
    if (valid_rst) state_d = ST_RESET;
    else begin
      unique case (state_q)
        ST_RUN:   if (hold_cmd_i && !hold_s_i) state_d = ST_HOLD;
        ST_HOLD:  if (hold_s_i)                state_d = ST_WAIT;
        ST_WAIT:  if (done_i)                  state_d = ST_RUN;
        ST_RESET:                              state_d = ST_WAIT;
        default:                               state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_RESET;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      load_q  <= (state_q == ST_WAIT) && (state_d == ST_RUN);
    end

  assign cnt_en_o   = (state_q == ST_WAIT);
  assign osc_en_o   = (state_q != ST_HOLD);
  assign core_run_o = (state_q == ST_RUN);
  assign core_rst_o = (state_q == ST_RESET);
  assign t0_load_o  = load_q;
  assign state_o    = state_q;

  a_r2_hold_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN && hold_cmd_i && !hold_s_i |=> state_q == ST_HOLD);
  a_r3_hold_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN && hold_cmd_i && hold_s_i && res_s_ni |=> state_q == ST_RUN);
  a_r4_hold_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HOLD && hold_s_i && res_s_ni |=> state_q == ST_WAIT && osc_en_o);
  a_r5_wait_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WAIT && done_i && res_s_ni |=> state_q == ST_RUN);
  a_r6_load_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t0_load_o |-> core_run_o && $past(state_q == ST_WAIT));
  a_r6_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t0_load_o |=> !t0_load_o);
  a_r7_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_s_ni && hold_s_i |=> state_q == ST_RESET);
  a_r8_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HOLD && !hold_s_i |=> state_q == ST_HOLD);
  a_r8_masked_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN && !hold_s_i && !hold_cmd_i |=> state_q == ST_RUN);
endmodule

// File: rtl/hold_wake_seq.sv
module hold_wake_seq
  import hws_pkg::*;
#(
  parameter int          WAIT_CYCLES = 16384,
  parameter int          SYNC_STAGES = 2,
  parameter int          T0_W        = 12,
  parameter logic [11:0] T0_PRESET   = 12'hFFC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_cmd_i,
  input  logic            hold_pin_i,
  input  logic            res_pin_ni,
  output logic            osc_en_o,
  output logic            core_run_o,
  output logic            core_rst_o,
  output logic            t0_load_o,
  output logic [T0_W-1:0] t0_value_o,
  output logic [1:0]      state_o
);
  logic       hold_s, res_s_n, done, cnt_en;
  hws_state_e state;

  hws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hold_pin_i), .q_o(hold_s));

  hws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_res (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(res_pin_ni), .q_o(res_s_n));

  hws_wait_cnt #(.WAIT_CYCLES(WAIT_CYCLES)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cnt_en), .done_o(done));

  hws_fsm #(.T0_W(T0_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_cmd_i (hold_cmd_i),
    .hold_s_i   (hold_s),
    .res_s_ni   (res_s_n),
    .done_i     (done),
    .cnt_en_o   (cnt_en),
    .osc_en_o   (osc_en_o),
    .core_run_o (core_run_o),
    .core_rst_o (core_rst_o),
    .t0_load_o  (t0_load_o),
    .state_o    (state)
  );

  assign t0_value_o = T0_W'(T0_PRESET);
  assign state_o    = state;

  a_r1_rst_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> !core_run_o && osc_en_o);
  a_r2_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd1 |-> !osc_en_o && !core_run_o);
endmodule

// File: tb/tb_hold_wake_seq.sv
`timescale 1ns/1ps
module tb_hold_wake_seq;
  localparam int N = 16384;

  logic        clk_i = 1'b0;
  logic        rst_ni, hold_cmd_i, hold_pin_i, res_pin_ni;
  logic        osc_en_o, core_run_o, core_rst_o, t0_load_o;
  logic [11:0] t0_value_o;
  logic [1:0]  state_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk_i = ~clk_i;

  hold_wake_seq dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wait_state(input logic [1:0] s);
    for (int i = 0; i < 100; i++) begin
      if (state_o == s) return;
      @(negedge clk_i);
    end
  endtask

  // expects to be called at a negedge with the block in WAIT
  task automatic measure_wait(input string req);
    int n = 0;
    while (state_o == 2'd2 && n < N + 10) begin
      check(osc_en_o && !core_run_o, "R4", {osc_en_o, core_run_o}, 2);
      n++;
      @(negedge clk_i);
    end
    check(n == N, {req, " R5 wait length"}, n, N);
    check(state_o == 2'd0 && core_run_o, "R5 run after wait", state_o, 0);
    check(t0_load_o == 1'b1, "R6 preload strobe", t0_load_o, 1);
    check(t0_value_o == 12'hFFC, "R6 preload value", t0_value_o, 12'hFFC);
    @(negedge clk_i);
    check(t0_load_o == 1'b0, "R6 strobe single cycle", t0_load_o, 0);
    check(core_run_o == 1'b1, "R6 still running", core_run_o, 1);
  endtask

  task automatic t_power_up;
    rst_ni = 0; hold_cmd_i = 0; hold_pin_i = 1; res_pin_ni = 0;
    wait_cycles(3);
    rst_ni = 1;
    wait_cycles(5);
    check(state_o == 2'd3, "R1 reset state", state_o, 3);
    check(core_rst_o && !core_run_o && osc_en_o, "R1 reset outputs",
          {core_rst_o, core_run_o, osc_en_o}, 5);
    res_pin_ni = 1;
    wait_state(2'd2);
    measure_wait("R7 power-up");
  endtask

  task automatic t_hold_refused;
    hold_cmd_i = 1; @(negedge clk_i); hold_cmd_i = 0;
    wait_cycles(3);
    check(state_o == 2'd0 && osc_en_o && core_run_o, "R3 strobe ignored", state_o, 0);
  endtask

  task automatic t_reset_masked_run;
    hold_pin_i = 0; wait_cycles(4);
    res_pin_ni = 0; wait_cycles(8);
    check(state_o == 2'd0 && !core_rst_o, "R8 masked in RUN", state_o, 0);
    res_pin_ni = 1; wait_cycles(4);
  endtask

  task automatic t_hold_cycle;
    hold_pin_i = 0; wait_cycles(4);
    hold_cmd_i = 1; @(negedge clk_i); hold_cmd_i = 0;
    check(state_o == 2'd1, "R2 hold entry", state_o, 1);
    check(!osc_en_o && !core_run_o, "R2 hold outputs", {osc_en_o, core_run_o}, 0);
    res_pin_ni = 0; wait_cycles(8);
    check(state_o == 2'd1 && !core_rst_o, "R8 masked in HOLD", state_o, 1);
    res_pin_ni = 1; wait_cycles(4);
    check(state_o == 2'd1, "R2 hold persists", state_o, 1);
    hold_pin_i = 1;
    wait_state(2'd2);
    check(state_o == 2'd2, "R4 wake to WAIT", state_o, 2);
    measure_wait("R4 hold exit");
  endtask

  task automatic t_reset_in_wait;
    hold_pin_i = 0; wait_cycles(4);
    hold_cmd_i = 1; @(negedge clk_i); hold_cmd_i = 0;
    hold_pin_i = 1;
    wait_state(2'd2);
    wait_cycles(100);
    res_pin_ni = 0; wait_cycles(4);
    check(state_o == 2'd3 && core_rst_o, "R7 reset in WAIT", state_o, 3);
    res_pin_ni = 1;
    wait_state(2'd2);
    measure_wait("R9 restart");
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk_i);
      cycles++;
    end
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=<200000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_power_up();
    t_hold_refused();
    t_reset_masked_run();
    t_hold_cycle();
    t_reset_in_wait();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule